// File: doc/BRIEF.md
# Pipeline Operand Forwarding Select

This block decides, for each of the two ALU operands of a five-stage in-order pipeline, where the execute stage should take its value from. It looks at the two source register numbers in the decode/execute pipeline register. It compares them with the destination register numbers and write enables in the execute/memory and memory/writeback pipeline registers. From these it produces one 2-bit mux select per operand.

The select can pass the value read from the register file. It can also pick the newer result waiting in execute/memory, or the older result waiting in memory/writeback. When both later stages target the same register, the newer one wins. A destination of register 0 never forwards, because that register always reads as zero.

The block is purely combinational and has no clock or state. The data muxes, the pipeline registers and the ALU sit outside it.

Top module: `fwd_select_unit`

## Requirements
- R1: When neither later stage qualifies as a producer for an operand, that operand's select is 2'b00 (register-file value).
- R2: Operand A select is 2'b10 when `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `dx_src_a`.
- R3: Operand A select is 2'b01 when `mwb_wr_en` is 1, `mwb_dst` is nonzero and `mwb_dst` equals `dx_src_a`, provided the R2 condition for operand A is false.
- R4: When both later stages qualify for the same operand, the select is 2'b10, so the execute/memory result wins over memory/writeback.
- R5: A destination of register 0 never causes forwarding, even when its write enable is 1; a source of register 0 therefore always selects 2'b00.
- R6: A stage whose write enable is 0 never causes forwarding, whatever its destination number.
- R7: Operand B select follows R1 to R6 using `dx_src_b`, independently of operand A.
- R8: The value 2'b11 never appears on either select, and the selects follow their inputs within the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exm_wr_en | input | 1 | Register write enable held in execute/memory |
| exm_dst | input | 5 | Destination register number held in execute/memory |
| mwb_wr_en | input | 1 | Register write enable held in memory/writeback |
| mwb_dst | input | 5 | Destination register number held in memory/writeback |
| dx_src_a | input | 5 | First source register number held in decode/execute |
| dx_src_b | input | 5 | Second source register number held in decode/execute |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_sel_b | output | 2 | Operand B select, same encoding |

## Verification
The bench targets the case where both later stages write the same source register. A design without the exclusion term would pick the stale memory/writeback value there, or would produce the illegal code 11. It also drives register 0 as a destination with its write enable set. A design missing the zero guard would forward a discarded result in place of the constant zero. Further vectors match a destination while its write enable is low, which catches a design that ignores the enable. Others set the two operands to differing sources, so that a design that crosses the A and B comparisons gives the wrong select.

// File: rtl/fwd_select_unit.sv
module fwd_select_unit #(
  parameter int REG_W = 5
) (
  input  logic             exm_wr_en,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             mwb_wr_en,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic [REG_W-1:0] dx_src_a,
  input  logic [REG_W-1:0] dx_src_b,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam logic [1:0] SEL_EXM = 2'b10;

  logic exm_live, mwb_live;
  logic exm_hit_a, exm_hit_b, mwb_hit_a, mwb_hit_b;

  assign exm_live = exm_wr_en && (exm_dst != '0);
  assign mwb_live = mwb_wr_en && (mwb_dst != '0);

  assign exm_hit_a = exm_live && (exm_dst == dx_src_a);
  assign exm_hit_b = exm_live && (exm_dst == dx_src_b);
  assign mwb_hit_a = mwb_live && (mwb_dst == dx_src_a);
  assign mwb_hit_b = mwb_live && (mwb_dst == dx_src_b);

  assign fwd_sel_a = exm_hit_a ? SEL_EXM : (mwb_hit_a ? SEL_MWB : SEL_RF);
  assign fwd_sel_b = exm_hit_b ? SEL_EXM : (mwb_hit_b ? SEL_MWB : SEL_RF);

endmodule

// File: rtl/fwd_select_unit_chk.sv
module fwd_select_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             exm_wr_en,
  input logic [REG_W-1:0] exm_dst,
  input logic             mwb_wr_en,
  input logic [REG_W-1:0] mwb_dst,
  input logic [REG_W-1:0] dx_src_a,
  input logic [REG_W-1:0] dx_src_b,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b
);

  always_comb begin
    AST_NO_CODE_11_A: assert (fwd_sel_a != 2'b11) else $error("illegal select A"); // R8
    AST_NO_CODE_11_B: assert (fwd_sel_b != 2'b11) else $error("illegal select B"); // R8
    AST_EXM_SRC_VALID_A: assert (fwd_sel_a != 2'b10 || (exm_wr_en && exm_dst != '0 && exm_dst == dx_src_a))
      else $error("select A chose execute/memory without a producer"); // R2
    AST_MWB_SRC_VALID_A: assert (fwd_sel_a != 2'b01 || (mwb_wr_en && mwb_dst != '0 && mwb_dst == dx_src_a))
      else $error("select A chose memory/writeback without a producer"); // R3
    AST_NEWEST_WINS_A: assert (!(exm_wr_en && mwb_wr_en && exm_dst == mwb_dst && exm_dst == dx_src_a && dx_src_a != '0) || fwd_sel_a == 2'b10)
      else $error("older producer won on A"); // R4
    AST_ZERO_SRC_A: assert (dx_src_a != '0 || fwd_sel_a == 2'b00) else $error("register 0 forwarded on A"); // R5
    AST_ZERO_SRC_B: assert (dx_src_b != '0 || fwd_sel_b == 2'b00) else $error("register 0 forwarded on B"); // R5
    AST_NO_WRITERS: assert (exm_wr_en || mwb_wr_en || (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00))
      else $error("forwarding without any write enable"); // R6
    AST_EXM_SRC_VALID_B: assert (fwd_sel_b != 2'b10 || (exm_wr_en && exm_dst != '0 && exm_dst == dx_src_b))
      else $error("select B chose execute/memory without a producer"); // R7
    AST_MWB_SRC_VALID_B: assert (fwd_sel_b != 2'b01 || (mwb_wr_en && mwb_dst != '0 && mwb_dst == dx_src_b))
      else $error("select B chose memory/writeback without a producer"); // R7
  end

endmodule

bind fwd_select_unit fwd_select_unit_chk #(.REG_W(REG_W)) chk_i (
  .exm_wr_en(exm_wr_en), .exm_dst(exm_dst),
  .mwb_wr_en(mwb_wr_en), .mwb_dst(mwb_dst),
  .dx_src_a(dx_src_a), .dx_src_b(dx_src_b),
  .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
);

// File: tb/fwd_select_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_select_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exm_wr_en = 1'b0, mwb_wr_en = 1'b0;
  logic [4:0] exm_dst = '0, mwb_dst = '0, dx_src_a = '0, dx_src_b = '0;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwd_select_unit dut_i (
    .exm_wr_en(exm_wr_en), .exm_dst(exm_dst),
    .mwb_wr_en(mwb_wr_en), .mwb_dst(mwb_dst),
    .dx_src_a(dx_src_a), .dx_src_b(dx_src_b),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  function automatic logic [1:0] model(input logic ew, input int ed, input logic mw, input int md, input int src);
    if (src == 0) return 2'b00;
    if (ew && ed == src) return 2'b10;
    if (mw && md == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string tag);
    logic [1:0] ea, eb;
    ea = model(exm_wr_en, exm_dst, mwb_wr_en, mwb_dst, dx_src_a);
    eb = model(exm_wr_en, exm_dst, mwb_wr_en, mwb_dst, dx_src_b);
    checks++;
    if (fwd_sel_a !== ea) begin
      errors++;
      $display("FAIL %s operand A: actual %b expected %b", tag, fwd_sel_a, ea);
    end
    checks++;
    if (fwd_sel_b !== eb) begin
      errors++;
      $display("FAIL %s operand B: actual %b expected %b", tag, fwd_sel_b, eb);
    end
  endtask

  task automatic drive(input string tag, input logic ew, input int ed, input logic mw, input int md,
                       input int sa, input int sb);
    @(posedge clk);
    exm_wr_en <= ew; exm_dst <= 5'(ed);
    mwb_wr_en <= mw; mwb_dst <= 5'(md);
    dx_src_a  <= 5'(sa); dx_src_b <= 5'(sb);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state");
    rst <= 1'b0;
    drive("R1 no match",            1, 7, 1, 9, 3, 4);
    drive("R2 exm match A",         1, 7, 0, 9, 7, 4);
    drive("R3 mwb match A",         1, 6, 1, 9, 9, 4);
    drive("R4 both match A",        1, 12, 1, 12, 12, 3);
    drive("R4 both match B",        1, 12, 1, 12, 3, 12);
    drive("R4 both match A and B",  1, 31, 1, 31, 31, 31);
    drive("R5 exm dest zero",       1, 0, 0, 5, 0, 0);
    drive("R5 zero dest, mwb live", 1, 0, 1, 8, 0, 8);
    drive("R5 both dest zero",      1, 0, 1, 0, 0, 0);
    drive("R6 exm disabled",        0, 7, 0, 7, 7, 7);
    drive("R6 exm off, mwb on",     0, 7, 1, 7, 7, 2);
    drive("R7 split A exm B mwb",   1, 10, 1, 11, 10, 11);
    drive("R7 split A mwb B exm",   1, 10, 1, 11, 11, 10);
    drive("R7 only B matches",      1, 20, 0, 0, 1, 20);
    for (int i = 0; i < 3000; i++) begin
      drive("R8 random", 1'($urandom), $urandom_range(0, 4), 1'($urandom), $urandom_range(0, 4),
            $urandom_range(0, 4), $urandom_range(0, 4));
    end
    for (int i = 0; i < 1000; i++) begin
      drive("R8 random wide", 1'($urandom), $urandom_range(0, 31), 1'($urandom), $urandom_range(0, 31),
            $urandom_range(0, 31), $urandom_range(0, 31));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule